// File: doc/BRIEF.md
# Double-Rate Field Repetition Sequencer

An interlaced source at 50 or 60 fields per second is shown at twice that field rate, with a two-slot field store. This sequencer follows the incoming fields and tags each one as A (odd lines) or B (even lines). At every doubled-rate output field start it picks which stored slot the display reads, and which parity the display should present. It also tells the store which slot to write and whether writing is allowed. Pixel storage and video timing are left to neighbouring blocks.

In live operation every completed field is shown for two output periods in a row, giving A A B B. When freeze is held, the sequencer waits for a complete frame to land, meaning a B field finishing after its A. It then blocks writes and alternates between the two held fields, giving A B A B. When freeze is dropped, writing resumes at the next incoming A field, and live repetition restarts once that A has fully arrived.

The output timing must be locked to the input, so that every input field start arrives in the same cycle as an output field start. Between two input starts there is one extra output start. All decisions are registered and are visible on the outputs one clock after the strobe that caused them.

Top module: `field_rep_seq`

## Requirements
- R1: After reset, rd_sel is 0, rd_par is 0 (B), wr_en is 0 and frozen is 0.
- R2: Writing stays disabled until the first input field start with in_par = 1 (A). From that start, wr_en is 1.
- R3: In live mode a field is selected at the output field start where it completes. rd_par then equals the parity of that field (1 = A, 0 = B). The field is shown again at the following output start, so alternating input parities give the output parity order A A B B.
- R4: Whenever wr_en is 1, wr_sel differs from rd_sel.
- R5: Freeze takes effect only at an input field start that completes a B field while freeze is high. Freeze held while an A completes has no effect on the output.
- R6: While frozen, wr_en is 0. Each output field start toggles both rd_sel and rd_par, so the output order is A B A B.
- R7: The frozen state is left only at an input field start with in_par = 1 while freeze is low, and writing resumes at that start. A B start with freeze low keeps the block frozen. Live A A B B display resumes when that A field completes.
- R8: A field whose start parity does not alternate is never displayed. A repeated A start discards the field in progress and restarts capture with the new A. A repeated B start disables writing until the next A start, and the output holds its last selection meanwhile.
- R9: When an input field start and an output field start fall in the same cycle, the field completed by that input start is the one selected in that cycle.
- R10: In cycles without an output field start, rd_sel and rd_par do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_fstart | input | 1 | One-cycle strobe: an input field begins |
| in_par | input | 1 | Parity of the starting input field, 1 = A (odd lines), 0 = B |
| out_fstart | input | 1 | One-cycle strobe: a doubled-rate output field begins |
| freeze | input | 1 | Level request to show a still frame |
| rd_sel | output | 1 | Store slot the display reads |
| rd_par | output | 1 | Parity presented for the current output field |
| wr_sel | output | 1 | Store slot the incoming field is written to |
| wr_en | output | 1 | Store write permission for the current input field |
| frozen | output | 1 | Still-frame display is active |

## Verification
The input field start that completes a field and the output field start that consumes it always land in the same cycle. So the field completion and the read selection collide on every input boundary. The bench strobes both together with alternating, repeated and frozen parities. On each collision it checks that the parity shown is the parity of the field that just finished, and never the one before it. It also checks that the write slot has already moved away from the slot now being read. Freeze engage and release are handled the same way: they occur on such a shared cycle, and the toggle rule or the take rule must win as the requirements state.

// File: rtl/field_rep_seq_pkg.sv
package field_rep_seq_pkg;

  typedef enum logic {
    PAR_B = 1'b0,
    PAR_A = 1'b1
  } fpar_e;

  localparam int SLOT_W = 1;

  // A field start is in order when its parity differs from the field before.
  function automatic logic par_in_order(input fpar_e prev, input fpar_e now);
    return now != prev;
  endfunction

  // The other slot of the two-slot store.
  function automatic logic [SLOT_W-1:0] other_slot(input logic [SLOT_W-1:0] s);
    return ~s;
  endfunction

endpackage

// File: rtl/fseq_tracker.sv
module fseq_tracker
  import field_rep_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_fstart,
  input  fpar_e in_par,
  output logic  sync_q,
  output fpar_e cur_par,
  output logic  field_ok,
  output logic  sync_d
);

  // Field ending at this start was captured in order.
  assign field_ok = in_fstart & sync_q & par_in_order(cur_par, in_par);
  // Stay locked on an in-order start; a fresh A always (re)acquires lock.
  assign sync_d   = in_fstart ? (field_ok | (in_par == PAR_A)) : sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      cur_par <= PAR_B;
    end else if (in_fstart) begin
      sync_q  <= sync_d;
      cur_par <= in_par;
    end
  end

  AST_LOCK_NEEDS_A: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> $past(in_par) == PAR_A); // R8

endmodule

// File: rtl/fseq_mode.sv
module fseq_mode
  import field_rep_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_fstart,
  input  fpar_e in_par,
  input  logic  freeze,
  input  logic  b_done,
  output logic  frozen,
  output logic  frozen_d,
  output logic  engage,
  output logic  release_ev
);

  assign engage     = in_fstart & b_done & freeze & ~frozen;
  assign release_ev = in_fstart & frozen & ~freeze & (in_par == PAR_A);
  assign frozen_d   = engage ? 1'b1 : (release_ev ? 1'b0 : frozen);

  always_ff @(posedge clk) begin
    if (!rst_n) frozen <= 1'b0;
    else        frozen <= frozen_d;
  end

  AST_RELEASE_AT_A: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frozen) |-> $past(in_fstart) && $past(in_par) == PAR_A && !$past(freeze)); // R7

  AST_ENGAGE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> $past(in_fstart) && $past(freeze)); // R5

endmodule

// File: rtl/fseq_reader.sv
module fseq_reader
  import field_rep_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_fstart,
  input  logic              frozen,
  input  logic              take,
  input  logic [SLOT_W-1:0] take_sel,
  input  fpar_e             take_par,
  output logic [SLOT_W-1:0] rd_sel,
  output fpar_e             rd_par,
  output logic [SLOT_W-1:0] rd_sel_d
);

  fpar_e rd_par_d;

  always_comb begin
    rd_sel_d = rd_sel;
    rd_par_d = rd_par;
    if (out_fstart) begin
      if (frozen) begin
        rd_sel_d = other_slot(rd_sel);
        rd_par_d = (rd_par == PAR_A) ? PAR_B : PAR_A;
      end else if (take) begin
        rd_sel_d = take_sel;
        rd_par_d = take_par;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_sel <= '0;
      rd_par <= PAR_B;
    end else begin
      rd_sel <= rd_sel_d;
      rd_par <= rd_par_d;
    end
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !out_fstart |=> $stable(rd_sel) && $stable(rd_par)); // R10

  AST_FROZEN_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && out_fstart) |=> rd_par != $past(rd_par) && rd_sel != $past(rd_sel)); // R6

endmodule

// File: rtl/field_rep_seq.sv
module field_rep_seq
  import field_rep_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_fstart,
  input  logic in_par,
  input  logic out_fstart,
  input  logic freeze,
  output logic rd_sel,
  output logic rd_par,
  output logic wr_sel,
  output logic wr_en,
  output logic frozen
);

  fpar_e in_par_e;
  fpar_e cur_par;
  fpar_e rd_par_e;
  logic  sync_q, sync_d, field_ok;
  logic  frozen_d, engage, release_ev;
  logic  done_ok, b_done, take;
  logic [SLOT_W-1:0] rd_sel_d, rd_sel_q, wr_sel_q;

  assign in_par_e = fpar_e'(in_par);

  fseq_tracker u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_fstart(in_fstart),
    .in_par   (in_par_e),
    .sync_q   (sync_q),
    .cur_par  (cur_par),
    .field_ok (field_ok),
    .sync_d   (sync_d)
  );

  // A field counts as complete only if it was actually written.
  assign done_ok = field_ok & wr_en;
  assign b_done  = done_ok & (cur_par == PAR_B);
  assign take    = done_ok & out_fstart;

  fseq_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_fstart (in_fstart),
    .in_par    (in_par_e),
    .freeze    (freeze),
    .b_done    (b_done),
    .frozen    (frozen),
    .frozen_d  (frozen_d),
    .engage    (engage),
    .release_ev(release_ev)
  );

  fseq_reader u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_fstart(out_fstart),
    .frozen    (frozen),
    .take      (take),
    .take_sel  (wr_sel_q),
    .take_par  (cur_par),
    .rd_sel    (rd_sel_q),
    .rd_par    (rd_par_e),
    .rd_sel_d  (rd_sel_d)
  );

  // Writer: each new field goes to the slot the reader will not be using.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en    <= 1'b0;
      wr_sel_q <= '0;
    end else if (in_fstart) begin
      wr_en    <= sync_d & ~frozen_d;
      wr_sel_q <= other_slot(rd_sel_d);
    end
  end

  assign rd_sel = rd_sel_q;
  assign wr_sel = wr_sel_q;
  assign rd_par = rd_par_e;

  AST_SLOTS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_sel_q != rd_sel_q); // R4

  AST_FROZEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !wr_en); // R6

  AST_ENGAGE_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
    engage |=> frozen && rd_par_e == PAR_B); // R5

  AST_TAKE_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !frozen) |=> rd_par_e == $past(cur_par) && rd_sel_q == $past(wr_sel_q)); // R9

  AST_NO_WRITE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fstart && !sync_d) |=> !wr_en); // R8

endmodule

// File: tb/field_rep_seq_test.sv
module field_rep_seq_test;

  typedef struct {
    logic  par;
    logic  frz;
    logic  wen;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_fstart = 1'b0, in_par = 1'b0, out_fstart = 1'b0, freeze = 1'b0;
  logic rd_sel, rd_par, wr_sel, wr_en, frozen;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;

  field_rep_seq uut (
    .clk(clk), .rst_n(rst_n), .in_fstart(in_fstart), .in_par(in_par),
    .out_fstart(out_fstart), .freeze(freeze), .rd_sel(rd_sel), .rd_par(rd_par),
    .wr_sel(wr_sel), .wr_en(wr_en), .frozen(frozen)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One output field period of four cycles.
  task automatic ofield(input bit fin, input bit p, input bit fz,
                        input bit ep, input bit ef, input bit ew, input string tag);
    exp_t e;
    @(negedge clk);
    in_fstart  = fin;
    in_par     = p;
    out_fstart = 1'b1;
    freeze     = fz;
    e.par = ep; e.frz = ef; e.wen = ew; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    in_fstart  = 1'b0;
    out_fstart = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compares after each output start, checks holds in between.
  initial begin
    logic last_sel, last_par;
    last_sel = 1'b0;
    last_par = 1'b0;
    forever begin
      @(posedge clk);
      if (mon_on) begin
        if (out_fstart) begin
          exp_t e;
          #1;
          if (sb.size() == 0) begin
            check("scoreboard underflow", 1'b1, 1'b0);
          end else begin
            e = sb.pop_front();
            check({e.tag, " rd_par"}, rd_par, e.par);
            check({e.tag, " frozen"}, frozen, e.frz);
            check({e.tag, " wr_en"}, wr_en, e.wen);
          end
          if (wr_en) check("R4 wr_sel vs ~rd_sel", wr_sel, ~rd_sel);
        end else begin
          #1;
          check("R10 rd_sel hold", rd_sel, last_sel);
          check("R10 rd_par hold", rd_par, last_par);
        end
        last_sel = rd_sel;
        last_par = rd_par;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_sel", rd_sel, 1'b0);
    check("R1 rd_par", rd_par, 1'b0);
    check("R1 wr_en", wr_en, 1'b0);
    check("R1 frozen", frozen, 1'b0);
    mon_on = 1'b1;

    // Lock acquisition
    ofield(1, 0, 0, 0, 0, 0, "R2 B before lock");
    ofield(1, 1, 0, 0, 0, 1, "R2 first A");
    ofield(0, 0, 0, 0, 0, 1, "R2 mid");
    // Live AABB, collisions on every input start
    ofield(1, 0, 0, 1, 0, 1, "R9 A completes");
    ofield(0, 0, 0, 1, 0, 1, "R3 A repeat");
    ofield(1, 1, 0, 0, 0, 1, "R3 B completes");
    ofield(0, 0, 0, 0, 0, 1, "R3 B repeat");
    // Freeze raised while an A completes: no effect yet
    ofield(1, 0, 1, 1, 0, 1, "R5 A done, no engage");
    ofield(0, 0, 1, 1, 0, 1, "R5 still live");
    ofield(1, 1, 1, 0, 1, 0, "R5 engage on B");
    ofield(0, 0, 1, 1, 1, 0, "R6 toggle to A");
    // Freeze dropped at a B start: stays frozen
    ofield(1, 0, 0, 0, 1, 0, "R7 B start keeps freeze");
    ofield(0, 0, 0, 1, 1, 0, "R6 toggle again");
    ofield(1, 1, 0, 0, 0, 1, "R7 release at A");
    ofield(0, 0, 0, 0, 0, 1, "R7 hold after release");
    ofield(1, 0, 0, 1, 0, 1, "R7 new A shown");
    ofield(0, 0, 0, 1, 0, 1, "R7 new A repeat");
    ofield(1, 1, 0, 0, 0, 1, "R7 B shown");
    ofield(0, 0, 0, 0, 0, 1, "R3 B repeat 2");
    // Repeated A start: restart capture
    ofield(1, 1, 0, 0, 0, 1, "R8 repeated A");
    ofield(0, 0, 0, 0, 0, 1, "R8 repeated A mid");
    ofield(1, 0, 0, 1, 0, 1, "R8 restarted A shown");
    ofield(0, 0, 0, 1, 0, 1, "R8 A repeat");
    // Repeated B start: lock lost until next A
    ofield(1, 0, 0, 1, 0, 0, "R8 repeated B");
    ofield(0, 0, 0, 1, 0, 0, "R8 unlocked mid");
    ofield(1, 0, 0, 1, 0, 0, "R8 B while unlocked");
    ofield(0, 0, 0, 1, 0, 0, "R8 unlocked mid 2");
    ofield(1, 1, 0, 1, 0, 1, "R8 relock at A");
    ofield(0, 0, 0, 1, 0, 1, "R8 relock mid");
    ofield(1, 0, 0, 1, 0, 1, "R8 relocked A shown");
    ofield(0, 0, 0, 1, 0, 1, "R3 A repeat 3");
    ofield(1, 1, 0, 0, 0, 1, "R3 B shown 3");
    repeat (3) @(negedge clk);
    check("scoreboard drained", sb.size() == 0, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule